// File: doc/BRIEF.md
# Dual-Clock Tagged FIFO Link

This block is a one-way, point-to-point FIFO channel between a producer and a consumer that run on unrelated clocks. It has no sharing and no arbitration. On each producer clock edge where the write strobe is high, the producer offers a 32-bit word together with a one-bit tag. The consumer sees the oldest stored word and its tag, plus a flag that says at least one entry is present. Each entry keeps its tag bit next to its word, so the pair always leaves the FIFO together.

The two sides tell each other how far they have got through pointers in Gray code. Each pointer passes through a two-stage synchronizer into the other clock domain. The full flag is derived in the producer domain and the exists flag in the consumer domain. The outputs fall through: when exists is high, the head entry is already on the consumer outputs, and a read strobe moves the head to the next entry. The depth is a power of two set by a parameter.

Top module: `xclk_tag_fifo`

## Requirements
- R1: After both resets, the FIFO is empty, `w_full` is low and `r_exists` is low.
- R2: Words leave on `r_data` in the order they were accepted, each unchanged.
- R3: A write strobe while `w_full` is high is ignored. The word is dropped and never appears at the consumer.
- R4: A read strobe while `r_exists` is low has no effect. The next word written is still the next word delivered.
- R5: The tag bit written with a word appears on `r_tag` whenever that word is on `r_data`.
- R6: With no reads, `w_full` is low through the first DEPTH-1 accepted writes and high right after the DEPTH-th. After entries are read, it falls again. Occupancy never exceeds DEPTH.
- R7: While `r_exists` is high and no read is strobed, `r_data` and `r_tag` keep showing the same head entry and `r_exists` stays high.
- R8: Each pointer that crosses between domains changes at most one bit per clock of its own domain.
- R9: `r_exists` rises within 3 consumer clocks after a word is written into an empty FIFO. It falls on the consumer clock edge that reads the last stored entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Producer clock |
| wrst_n | input | 1 | Producer-side asynchronous reset, active low |
| w_data | input | 32 | Word offered by the producer |
| w_tag | input | 1 | Control tag stored with the word |
| w_push | input | 1 | Write strobe, sampled on `wclk` |
| w_full | output | 1 | No free entry; writes are dropped |
| rclk | input | 1 | Consumer clock |
| rrst_n | input | 1 | Consumer-side asynchronous reset, active low |
| r_data | output | 32 | Head word, valid while `r_exists` is high |
| r_tag | output | 1 | Tag of the head word |
| r_pop | input | 1 | Read strobe, sampled on `rclk` |
| r_exists | output | 1 | At least one entry is stored |

## Verification
Assertions run on every cycle and check four things: a strobe against full or against empty leaves its pointer where it was, each crossing pointer moves by at most one Gray bit, occupancy stays within the depth, and the head entry holds still while it waits. The bench scenarios are needed for the end-to-end properties. These are ordering and intact delivery of word and tag across two unrelated clocks, the exact write on which full rises, the loss of dropped words, and how long it takes a first word to become visible through the synchronizers.

// File: rtl/xtf_pkg.sv
package xtf_pkg;
  localparam int XTF_WORD_W = 32;

  typedef struct packed {
    logic                  tag;
    logic [XTF_WORD_W-1:0] word;
  } xtf_entry_t;
endpackage

// File: rtl/xtf_sync.sv
module xtf_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xtf_wr_side.sv
module xtf_wr_side #(
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          push,
  input  logic [AW:0]   rgray_s,
  output logic          full,
  output logic          wr_en,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] bin_to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin;
  logic [PW-1:0] wbin_nx;
  logic [PW-1:0] rbin_s;
  logic [PW-1:0] occ;
  logic          drop_ev;

  assign rbin_s  = gray_to_bin(rgray_s);
  assign occ     = wbin - rbin_s;
  assign full    = (wbin[PW-1] != rbin_s[PW-1]) && (wbin[AW-1:0] == rbin_s[AW-1:0]);
  assign wr_en   = push && !full;
  assign drop_ev = push && full;
  assign wbin_nx = wbin + PW'(1);
  assign waddr   = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_en) begin
      wbin  <= wbin_nx;
      wgray <= bin_to_gray(wbin_nx);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
    drop_ev |=> $stable(wbin));

  assert_wgray_step_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
    1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

  assert_occupancy_bound_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
    occ <= DEPTH_P);
endmodule

// File: rtl/xtf_rd_side.sv
module xtf_rd_side #(
  parameter int AW = 3
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          pop,
  input  logic [AW:0]   wgray_s,
  output logic          exists,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray
);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] bin_to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rbin;
  logic [PW-1:0] rbin_nx;
  logic [PW-1:0] wbin_s;
  logic          rd_en;
  logic          empty_pop_ev;

  assign wbin_s       = gray_to_bin(wgray_s);
  assign exists       = (rbin != wbin_s);
  assign rd_en        = pop && exists;
  assign empty_pop_ev = pop && !exists;
  assign rbin_nx      = rbin + PW'(1);
  assign raddr        = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_en) begin
      rbin  <= rbin_nx;
      rgray <= bin_to_gray(rbin_nx);
    end
  end

  assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty_pop_ev |=> $stable(rbin));

  assert_rgray_step_R8: assert property (@(posedge rclk) disable iff (!rrst_n)
    1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1));
endmodule

// File: rtl/xtf_store.sv
module xtf_store #(
  parameter int AW = 3
) (
  input  logic                  wclk,
  input  logic                  wr_en,
  input  logic [AW-1:0]         waddr,
  input  xtf_pkg::xtf_entry_t   wr_entry,
  input  logic [AW-1:0]         raddr,
  output xtf_pkg::xtf_entry_t   rd_entry
);
  localparam int DEPTH = 1 << AW;

  xtf_pkg::xtf_entry_t mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (wr_en) mem[waddr] <= wr_entry;
  end

  assign rd_entry = mem[raddr];
endmodule

// File: rtl/xclk_tag_fifo.sv
module xclk_tag_fifo #(
  parameter int DEPTH_LOG2 = 3
) (
  input  logic                          wclk,
  input  logic                          wrst_n,
  input  logic [xtf_pkg::XTF_WORD_W-1:0] w_data,
  input  logic                          w_tag,
  input  logic                          w_push,
  output logic                          w_full,
  input  logic                          rclk,
  input  logic                          rrst_n,
  output logic [xtf_pkg::XTF_WORD_W-1:0] r_data,
  output logic                          r_tag,
  input  logic                          r_pop,
  output logic                          r_exists
);
  localparam int AW = DEPTH_LOG2;
  localparam int PW = AW + 1;

  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic          wr_en;
  xtf_pkg::xtf_entry_t wr_entry, rd_entry;

  assign wr_entry.tag  = w_tag;
  assign wr_entry.word = w_data;
  assign r_data        = rd_entry.word;
  assign r_tag         = rd_entry.tag;

  xtf_wr_side #(.AW(AW)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .push(w_push), .rgray_s(rgray_s),
    .full(w_full), .wr_en(wr_en), .waddr(waddr), .wgray(wgray)
  );

  xtf_sync #(.W(PW)) u_sync_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
  );

  xtf_sync #(.W(PW)) u_sync_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
  );

  xtf_rd_side #(.AW(AW)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .pop(r_pop), .wgray_s(wgray_s),
    .exists(r_exists), .raddr(raddr), .rgray(rgray)
  );

  xtf_store #(.AW(AW)) u_store (
    .wclk(wclk), .wr_en(wr_en), .waddr(waddr), .wr_entry(wr_entry),
    .raddr(raddr), .rd_entry(rd_entry)
  );

  assert_head_hold_R7: assert property (@(posedge rclk) disable iff (!rrst_n)
    (r_exists && !r_pop) |=> (r_exists && $stable(r_data) && $stable(r_tag)));
endmodule

// File: tb/xclk_tag_fifo_bench.sv
module xclk_tag_fifo_bench;
  localparam int LOG2  = 3;
  localparam int DEPTH = 1 << LOG2;

  logic        wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic [31:0] w_data = '0, r_data;
  logic        w_tag = 0, w_push = 0, w_full, r_tag, r_pop, r_exists;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  xclk_tag_fifo #(.DEPTH_LOG2(LOG2)) u_xclk_tag_fifo (
    .wclk(wclk), .wrst_n(wrst_n), .w_data(w_data), .w_tag(w_tag), .w_push(w_push),
    .w_full(w_full), .rclk(rclk), .rrst_n(rrst_n), .r_data(r_data), .r_tag(r_tag),
    .r_pop(r_pop), .r_exists(r_exists)
  );

  logic [32:0] exp_q[$];
  int  checks = 0, fails = 0;
  bit  mon_en = 0, mon_throttle = 0, force_pop = 0;
  int  rcyc = 0;

  task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: compares the head against the scoreboard, then pops it
  initial begin
    r_pop = 0;
    forever begin
      @(negedge rclk);
      rcyc++;
      if (mon_en && r_exists && !(mon_throttle && (rcyc % 3 == 0))) begin
        if (exp_q.size() == 0) begin
          check(0, "R3 unexpected word", {r_tag, r_data}, 33'h0);
        end else begin
          check(r_data == exp_q[0][31:0], "R2 data order", {1'b0, r_data}, {1'b0, exp_q[0][31:0]});
          check(r_tag == exp_q[0][32], "R5 tag with word", {32'h0, r_tag}, {32'h0, exp_q[0][32]});
          void'(exp_q.pop_front());
        end
        r_pop = 1;
      end else begin
        r_pop = force_pop;
      end
    end
  end

  // Driver: one strobe; the scoreboard keeps the word only if full is low
  task automatic push_word(input logic [31:0] d, input logic t, input bit wait_room);
    @(negedge wclk);
    if (wait_room) while (w_full) @(negedge wclk);
    w_data = d; w_tag = t; w_push = 1;
    if (!w_full) exp_q.push_back({t, d});
    @(negedge wclk);
    w_push = 0;
  endtask

  task automatic drain();
    mon_en = 1;
    while (exp_q.size() != 0) @(negedge rclk);
    repeat (2) @(negedge rclk);
  endtask

  initial begin
    repeat (100000) @(posedge wclk);
    fails++;
    $display("FAIL watchdog actual=hung expected=completion");
    finish_up();
  end

  initial begin
    int lat;
    repeat (4) @(negedge wclk);
    wrst_n = 1; rrst_n = 1;
    @(negedge rclk);
    check(w_full == 0, "R1 full after reset", {32'h0, w_full}, 33'h0);
    check(r_exists == 0, "R1 exists after reset", {32'h0, r_exists}, 33'h0);

    // R4: reads against an empty FIFO
    force_pop = 1;
    repeat (4) @(negedge rclk);
    force_pop = 0;
    @(negedge rclk);
    check(r_exists == 0, "R4 exists after empty pops", {32'h0, r_exists}, 33'h0);

    // R9 latency and R7 hold of a single word
    push_word(32'hA5A5_0001, 1'b1, 0);
    lat = 0;
    while (!r_exists && lat < 10) begin @(negedge rclk); lat++; end
    check(lat <= 3, "R9 exists latency", 33'(lat), 33'd3);
    check(r_data == 32'hA5A5_0001 && r_tag == 1'b1, "R4 R7 head after empty pops", {r_tag, r_data}, {1'b1, 32'hA5A5_0001});
    repeat (3) @(negedge rclk);
    check(r_exists && r_data == 32'hA5A5_0001 && r_tag == 1'b1, "R7 head held", {r_tag, r_data}, {1'b1, 32'hA5A5_0001});
    drain();
    check(r_exists == 0, "R9 exists falls after last read", {32'h0, r_exists}, 33'h0);
    mon_en = 0;

    // R6 fill, R3 writes while full
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) begin
        @(negedge wclk);
        check(w_full == 0, "R6 not full before last slot", {32'h0, w_full}, 33'h0);
      end
      push_word(32'h1000_0000 + 32'(i * 7), 1'(i), 0);
    end
    check(w_full == 1, "R6 full after DEPTH writes", {32'h0, w_full}, 33'h1);
    push_word(32'hDEAD_0001, 1'b1, 0);
    push_word(32'hDEAD_0002, 1'b0, 0);
    check(exp_q.size() == DEPTH, "R3 dropped writes not queued", 33'(exp_q.size()), 33'(DEPTH));
    drain();
    check(r_exists == 0, "R3 no dropped word emerges", {32'h0, r_exists}, 33'h0);
    repeat (4) @(negedge wclk);
    check(w_full == 0, "R6 full falls after reads", {32'h0, w_full}, 33'h0);

    // R2 R5 streaming with concurrent reads, steady then throttled
    for (int i = 0; i < 120; i++) begin
      mon_throttle = (i >= 60);
      push_word((32'(i) * 32'h9E37_79B1) ^ 32'h5A00_00C3, 1'(i[0] ^ i[2]), 1);
    end
    drain();
    check(r_exists == 0 && exp_q.size() == 0, "R2 stream fully delivered", {32'h0, r_exists}, 33'h0);
    finish_up();
  end
endmodule